// File: doc/BRIEF.md
# USB Full-Speed Link State Monitor

This block watches the received D+ and D- levels of a full-speed USB device port, a VBUS sense input and a start-of-frame pulse from the protocol engine. It runs in the 48 MHz line clock domain, which is four times the 12 Mb/s bit rate. From these inputs it keeps a two-bit link state: detached, bus reset, suspended or active. Each state change and each missing-frame condition also produces a one-cycle event pulse, which downstream interrupt logic latches.

Bus reset, suspend and lost-host conditions are told apart by how long a line condition lasts. A single-ended zero held for 3 us is a bus reset. Idle J held for 3 ms is suspend. In the active state, 4.096 ms with no start-of-frame means the host has been lost. These durations are given as cycle-count parameters. The D+ pullup request simply follows the interface enable.

Top module: `usb_link_monitor`

## Requirements
- R1: Synchronous reset (rst_n low at a rising edge) forces link_state to 0 (detached) and clears all event outputs. Encoding: 0 detached, 1 bus reset, 2 suspended, 3 active.
- R2: A low vbus_sense at a rising edge puts link_state at 0 after that edge. ev_disconnect pulses for one cycle only when the state was not already detached.
- R3: SE0 (rx_dp=0, rx_dn=0) sets link_state to 1 and pulses ev_reset at the edge of its SE0_CYCLES-th consecutive cycle, from any state, provided vbus_sense is high. Any non-SE0 cycle restarts the count.
- R4: In bus reset, the first cycle with vbus_sense high and no SE0 moves link_state to 3 at the following edge.
- R5: In the active state, idle J (rx_dp=1, rx_dn=0) held for IDLE_CYCLES consecutive cycles moves link_state to 2 and pulses ev_suspend at that edge. Any non-J cycle restarts the count.
- R6: Any exit from the suspended state pulses ev_resume for one cycle at the edge of the exit. A non-J line cycle while suspended exits to active.
- R7: While active, SOF_GAP_CYCLES consecutive cycles with no sof_pulse pulse ev_host_lost once, and link_state stays 3. A sof_pulse cycle, or entry into active, restarts the count.
- R8: dp_pullup equals if_enable at all times, independent of link state.
- R9: Each event fires once per qualifying condition. A condition that keeps holding past its threshold does not fire again. ev_reset, ev_suspend and ev_host_lost never pulse together.
- R10: With vbus_sense high and no bus reset detected, the detached state is kept. A connect alone does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vbus_sense | input | 1 | High while the host supplies VBUS |
| if_enable | input | 1 | Interface enable |
| rx_dp | input | 1 | Received D+ level |
| rx_dn | input | 1 | Received D- level |
| sof_pulse | input | 1 | One-cycle start-of-frame strobe from the protocol engine |
| link_state | output | 2 | 0 detached, 1 bus reset, 2 suspended, 3 active |
| ev_disconnect | output | 1 | Pulse on entering detached |
| ev_reset | output | 1 | Pulse on bus reset detection |
| ev_suspend | output | 1 | Pulse on entering suspended |
| ev_resume | output | 1 | Pulse on leaving suspended |
| ev_host_lost | output | 1 | Pulse on a missing start-of-frame window |
| dp_pullup | output | 1 | D+ pullup request |

## Verification
The link state and all events are registered. They change at the rising edge that ends the deciding cycle. For the duration rules, that is the edge of the N-th consecutive qualifying cycle. The pullup is combinational and is due in the same cycle as the enable change. The bench drives inputs at falling edges and counts the exact number of rising edges each input pattern is held. It samples at the falling edge after the last counted edge. For every threshold it also samples one edge early, so that an off-by-one in either direction shows up as a mismatch.

// File: rtl/usb_link_pkg.sv
// Shared types for the link state monitor.
// Assumes: the state codes are visible at the top port and must keep their values.
package usb_link_pkg;

    typedef enum logic [1:0] {
        LINK_DETACHED  = 2'd0,
        LINK_BUS_RESET = 2'd1,
        LINK_SUSPENDED = 2'd2,
        LINK_ACTIVE    = 2'd3
    } link_state_e;

    typedef struct packed {
        logic detach;
        logic bus_reset;
        logic suspend;
        logic resume;
        logic host_lost;
    } link_events_t;

endpackage

// File: rtl/usb_line_decode.sv
// Classifies the received line pair into SE0 and idle J.
// Assumes: rx_dp/rx_dn are already recovered and synchronous to the line clock;
// J is D+ high with D- low (full-speed polarity).
module usb_line_decode (
    input  logic rx_dp,
    input  logic rx_dn,
    output logic line_se0,
    output logic line_j
);

    // Decode the two symbols the duration timers care about.
    always_comb begin
        line_se0 = !rx_dp && !rx_dn;
        line_j   = rx_dp && !rx_dn;
    end

endmodule

// File: rtl/usb_hold_timer.sv
// Measures how long a condition has held without a break. The counter clears
// whenever run is low and saturates at LIMIT. expired is high in the cycle that is
// the LIMIT-th consecutive run cycle, and only once per unbroken run.
// Assumes: LIMIT >= 2.
module usb_hold_timer #(
    parameter int LIMIT = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count consecutive run cycles, clearing on a break and saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!run)        cnt_q <= '0;
        else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end

    // Flag the cycle in which the run reaches its LIMIT-th cycle.
    always_comb expired = run && (cnt_q == LAST);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    p_single_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
    p_break_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/usb_link_fsm.sv
// Link state machine. It combines the sense level, the line symbols and the three
// timer expiries into the link state and registered one-cycle event pulses.
// Priority: a lost VBUS wins, then bus-reset detection, then per-state moves.
// Assumes: the expiry inputs come from usb_hold_timer instances (single pulses).
module usb_link_fsm
    import usb_link_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sense,
    input  logic         line_se0,
    input  logic         line_j,
    input  logic         se0_done,
    input  logic         idle_done,
    input  logic         sof_done,
    output link_state_e  state,
    output link_events_t events
);

    link_state_e  state_q, state_d;
    link_events_t ev_q, ev_d;

    // Choose the next link state by priority.
    always_comb begin
        state_d = state_q;
        if (!sense)        state_d = LINK_DETACHED;
        else if (se0_done) state_d = LINK_BUS_RESET;
        else begin
            case (state_q)
                LINK_BUS_RESET: if (!line_se0) state_d = LINK_ACTIVE;
                LINK_ACTIVE:    if (idle_done) state_d = LINK_SUSPENDED;
                LINK_SUSPENDED: if (!line_j)   state_d = LINK_ACTIVE;
                default:        state_d = state_q;
            endcase
        end
    end

    // Derive the event pulses from the transition being taken.
    always_comb begin
        ev_d.detach    = (state_q != LINK_DETACHED) && (state_d == LINK_DETACHED);
        ev_d.bus_reset = sense && se0_done;
        ev_d.suspend   = (state_q == LINK_ACTIVE) && (state_d == LINK_SUSPENDED);
        ev_d.resume    = (state_q == LINK_SUSPENDED) && (state_d != LINK_SUSPENDED);
        ev_d.host_lost = sof_done && (state_q == LINK_ACTIVE) && (state_d == LINK_ACTIVE);
    end

    // Register the state and the events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_DETACHED;
            ev_q    <= '0;
        end else begin
            state_q <= state_d;
            ev_q    <= ev_d;
        end
    end

    assign state  = state_q;
    assign events = ev_q;

    p_detach_on_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sense |=> state_q == LINK_DETACHED);
    p_detach_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.detach |=> !ev_q.detach);
    p_reset_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.bus_reset |-> state_q == LINK_BUS_RESET);
    p_reset_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LINK_BUS_RESET && sense && !line_se0) |=> state_q == LINK_ACTIVE);
    p_suspend_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.suspend |-> (state_q == LINK_SUSPENDED && $past(state_q) == LINK_ACTIVE));
    p_resume_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LINK_SUSPENDED && $past(state_q) == LINK_SUSPENDED) |-> ev_q.resume);
    p_host_lost_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.host_lost |-> state_q == LINK_ACTIVE);
    p_excl_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_q.bus_reset, ev_q.suspend, ev_q.host_lost}));

endmodule

// File: rtl/usb_link_monitor.sv
// Top of the link state monitor: line decode, three duration timers (SE0, idle J,
// start-of-frame gap) and the link state machine. The pullup request follows the
// enable directly.
// Assumes: 48 MHz clock; the default cycle counts are 3 us, 3 ms and 4.096 ms.
module usb_link_monitor #(
    parameter int SE0_CYCLES     = 144,
    parameter int IDLE_CYCLES    = 144000,
    parameter int SOF_GAP_CYCLES = 196608
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_sense,
    input  logic       if_enable,
    input  logic       rx_dp,
    input  logic       rx_dn,
    input  logic       sof_pulse,
    output logic [1:0] link_state,
    output logic       ev_disconnect,
    output logic       ev_reset,
    output logic       ev_suspend,
    output logic       ev_resume,
    output logic       ev_host_lost,
    output logic       dp_pullup
);
    import usb_link_pkg::*;

    logic         line_se0, line_j;
    logic         se0_done, idle_done, sof_done, sof_run;
    link_state_e  state;
    link_events_t events;

    usb_line_decode u_decode (
        .rx_dp    (rx_dp),
        .rx_dn    (rx_dn),
        .line_se0 (line_se0),
        .line_j   (line_j)
    );

    usb_hold_timer #(.LIMIT(SE0_CYCLES)) u_se0_timer (
        .clk (clk), .rst_n (rst_n), .run (line_se0), .expired (se0_done)
    );

    usb_hold_timer #(.LIMIT(IDLE_CYCLES)) u_idle_timer (
        .clk (clk), .rst_n (rst_n), .run (line_j), .expired (idle_done)
    );

    // The frame-gap timer only runs while active and restarts on every SOF.
    always_comb sof_run = (state == LINK_ACTIVE) && !sof_pulse;

    usb_hold_timer #(.LIMIT(SOF_GAP_CYCLES)) u_sof_timer (
        .clk (clk), .rst_n (rst_n), .run (sof_run), .expired (sof_done)
    );

    usb_link_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense     (vbus_sense),
        .line_se0  (line_se0),
        .line_j    (line_j),
        .se0_done  (se0_done),
        .idle_done (idle_done),
        .sof_done  (sof_done),
        .state     (state),
        .events    (events)
    );

    // Map the internal types onto plain output ports.
    always_comb begin
        link_state    = state;
        ev_disconnect = events.detach;
        ev_reset      = events.bus_reset;
        ev_suspend    = events.suspend;
        ev_resume     = events.resume;
        ev_host_lost  = events.host_lost;
        dp_pullup     = if_enable;
    end

endmodule

// File: tb/usb_link_monitor_test.sv
// Bench for usb_link_monitor with shortened thresholds (SE0 8, idle 40, gap 60).
// A vector table is walked first, then directed corner cases follow.
module usb_link_monitor_test;

    logic clk = 1'b0;
    logic rst_n, sense, en, dp, dn, sof;
    logic [1:0] st;
    logic ev_dc, ev_rs, ev_su, ev_re, ev_hl, pull;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usb_link_monitor #(.SE0_CYCLES(8), .IDLE_CYCLES(40), .SOF_GAP_CYCLES(60)) uut (
        .clk (clk), .rst_n (rst_n), .vbus_sense (sense), .if_enable (en),
        .rx_dp (dp), .rx_dn (dn), .sof_pulse (sof), .link_state (st),
        .ev_disconnect (ev_dc), .ev_reset (ev_rs), .ev_suspend (ev_su),
        .ev_resume (ev_re), .ev_host_lost (ev_hl), .dp_pullup (pull)
    );

    wire [4:0] evs = {ev_dc, ev_rs, ev_su, ev_re, ev_hl};

    // Fields: [18] sense [17] sof [16] dp [15] dn [14:7] hold edges [6:5] state [4:0] events
    // Event order: {disconnect, reset, suspend, resume, host_lost}
    localparam logic [18:0] VEC [17] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd3,  2'd0, 5'b00000}, // R2 R10 unsensed stays detached
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd2,  2'd0, 5'b00000}, // R10 connect alone no change
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd7,  2'd0, 5'b00000}, // R3 one short of threshold
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd1,  2'd1, 5'b01000}, // R3 reset at 8th SE0
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  2'd1, 5'b00000}, // R9 no repeat reset
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  2'd3, 5'b00000}, // R4 SE0 ends -> active
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd10, 2'd3, 5'b00000}, // R7 short gap
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd1,  2'd3, 5'b00000}, // R7 sof restarts gap
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd38, 2'd3, 5'b00000}, // R5 39 J cycles
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  2'd2, 5'b00100}, // R5 suspend at 40th J
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd30, 2'd2, 5'b00000}, // R9 stays suspended, no repeat
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  2'd3, 5'b00010}, // R6 K resumes
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd59, 2'd3, 5'b00000}, // R7 one short of gap
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  2'd3, 5'b00001}, // R7 host lost
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 2'd3, 5'b00000}, // R9 host lost once
        {1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  2'd0, 5'b10000}, // R2 disconnect
        {1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  2'd0, 5'b00000}  // R2 no repeat disconnect
    };

    task automatic check(input string tag, input logic [1:0] es, input logic [4:0] ee);
        checks += 2;
        if (st !== es) begin
            failures++;
            $display("FAIL %s link_state act=%0d exp=%0d", tag, st, es);
        end
        if (evs !== ee) begin
            failures++;
            $display("FAIL %s events act=%b exp=%b", tag, evs, ee);
        end
    endtask

    task automatic check_pull(input string tag, input logic exp);
        checks++;
        if (pull !== exp) begin
            failures++;
            $display("FAIL %s dp_pullup act=%b exp=%b", tag, pull, exp);
        end
    endtask

    // Drive a line pattern at a falling edge and hold it for n rising edges.
    task automatic hold(input logic s, input logic f, input logic p, input logic m, input int n);
        sense = s; sof = f; dp = p; dn = m;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; sense = 1'b0; sof = 1'b0; dp = 1'b1; dn = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 2'd0, 5'b00000);
        check_pull("R8 pullup on", 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < 17; i++) begin
            hold(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15], int'(VEC[i][14:7]));
            check($sformatf("R%0d-row%0d", (i < 2) ? 10 : 0, i), VEC[i][6:5], VEC[i][4:0]);
        end

        // R8: pullup follows enable in any state
        en = 1'b0; #1;
        check_pull("R8 pullup off", 1'b0);
        en = 1'b1; #1;
        check_pull("R8 pullup back", 1'b1);

        // R3: an interrupted SE0 restarts the count
        hold(1'b1, 1'b0, 1'b0, 1'b0, 7);
        hold(1'b1, 1'b0, 1'b1, 1'b0, 1);
        hold(1'b1, 1'b0, 1'b0, 1'b0, 7);
        check("R3 restart no reset", 2'd0, 5'b00000);
        hold(1'b1, 1'b0, 1'b0, 1'b0, 1);
        check("R3 reset after restart", 2'd1, 5'b01000);

        // R6: SE0 while suspended resumes first, then resets
        hold(1'b1, 1'b0, 1'b1, 1'b0, 1);
        check("R4 J exits reset", 2'd3, 5'b00000);
        hold(1'b1, 1'b0, 1'b1, 1'b0, 39);
        check("R5 suspend", 2'd2, 5'b00100);
        hold(1'b1, 1'b0, 1'b0, 1'b0, 1);
        check("R6 SE0 resumes", 2'd3, 5'b00010);
        hold(1'b1, 1'b0, 1'b0, 1'b0, 7);
        check("R3 reset from resumed", 2'd1, 5'b01000);

        // R6 R2: losing VBUS while suspended gives disconnect and resume together
        hold(1'b1, 1'b0, 1'b1, 1'b0, 40);
        check("R5 suspend again", 2'd2, 5'b00100);
        hold(1'b0, 1'b0, 1'b1, 1'b0, 1);
        check("R6 R2 detach from suspend", 2'd0, 5'b10010);

        // R7: a SOF on the would-be expiry cycle prevents host lost
        hold(1'b1, 1'b0, 1'b0, 1'b0, 8);
        check("R3 reset for gap test", 2'd1, 5'b01000);
        hold(1'b1, 1'b0, 1'b0, 1'b1, 1);
        check("R4 K exits reset", 2'd3, 5'b00000);
        hold(1'b1, 1'b0, 1'b0, 1'b1, 59);
        hold(1'b1, 1'b1, 1'b0, 1'b1, 1);
        check("R7 sof at boundary", 2'd3, 5'b00000);
        hold(1'b1, 1'b0, 1'b0, 1'b1, 59);
        check("R7 gap one short", 2'd3, 5'b00000);
        hold(1'b1, 1'b0, 1'b0, 1'b1, 1);
        check("R7 host lost after sof", 2'd3, 5'b00001);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 2'd0, 5'b00000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as one extra failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end

endmodule